// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

The block adds two unsigned operands held in two right-shifting registers using one full-adder cell and a carry flip-flop, one bit per clock, least significant bit first. Each operand register has a next-value multiplexer. Its select picks either the parallel load word or the serial path. On the serial path, register A takes the sum bit from the adder and register B takes its own outgoing bit. After one pass of `WIDTH` shifts, A holds the sum and B is back at its original value.

A small controller sits in an idle state until a load or start request arrives. On a start it clears the carry flip-flop and the bit counter, then issues exactly `WIDTH` shift cycles with `busy` high. After the last shift it pulses `done` for one cycle and shows the final carry on `carry_out`. A new addition is accepted once the block is back in idle. A user loads both operands, asserts `start` for one cycle, waits for `done`, and then reads the sum from `a_out`.

Top module: `serial_adder`

## Requirements
- R1: While reset is asserted and directly after it, `a_out`, `b_out` and `carry_out` are 0 and `busy` and `done` are low.
- R2: In idle, `load` high at a clock edge copies `a_in` into A and `b_in` into B at that edge.
- R3: In idle, if `load` and `start` are both high at the same edge, the load happens and no addition begins (`busy` stays low).
- R4: A `start` accepted in idle makes `busy` high for exactly `WIDTH` (default 8) cycles. `done` goes high in the cycle right after the last busy cycle.
- R5: When `done` is high, `a_out` equals (A + B) mod 2^`WIDTH`, using the operand values held when `start` was accepted. The sum bit enters A at its most significant position on each shift.
- R6: When `done` is high, `b_out` equals the value B held when `start` was accepted.
- R7: When `done` is high, `carry_out` equals bit `WIDTH` of the full-precision sum A + B.
- R8: While `busy` is high, `load` and `start` have no effect: the result, B and the busy length are the same as without them.
- R9: The carry flip-flop is cleared when an addition starts, so a carry left over from the previous addition does not enter the next sum.
- R10: `done` is a single-cycle pulse and is never high together with `busy`. The bit counter wraps to 0 after its last count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Parallel load of both operands (idle only) |
| start | input | 1 | Begin an addition (idle only) |
| a_in | input | WIDTH | Load value for register A |
| b_in | input | WIDTH | Load value for register B |
| a_out | output | WIDTH | Contents of register A (sum after done) |
| b_out | output | WIDTH | Contents of register B |
| busy | output | 1 | High during the shift cycles |
| done | output | 1 | One-cycle pulse after the last shift |
| carry_out | output | 1 | Carry flip-flop; final carry when done |

## Verification
The operand table covers zero plus zero, a carry that ripples through every bit (FF+01, 7F+01), complementary patterns with no carry at all (55+AA, 3C+C3), a carry produced only at the top bit (80+80), and full saturation (FF+FF). Together these cases separate a missing carry feedback, a wrong shift direction, a missing recirculation of B and a carry that is never cleared. Directed runs then place load-with-start in idle, load and start in the middle of an addition, and a zero addition straight after one that ended with a carry. Each run also counts the busy cycles so that an off-by-one in the controller is caught.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sadd_state_e;

    // Controller outputs: register update enables, next-value selects
    // (1 = parallel word, 0 = serial path), carry clear, counter clear.
    typedef struct packed {
        logic shift_a;
        logic shift_b;
        logic sel_a;
        logic sel_b;
        logic clr_carry;
        logic clr_cnt;
    } sadd_ctl_t;

endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sel,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (en) begin
            if (sel) q_d = par_in;
            else     q_d = {ser_in, q_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

    // R5
    ser_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sel) |=> (q_q[WIDTH-1] == $past(ser_in)));

endmodule

// File: rtl/sadd_bitcell.sv
module sadd_bitcell (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry
);

    logic carry_d, carry_q, cout;

    always_comb begin
        sum_bit = a_bit ^ b_bit ^ carry_q;
        cout    = (a_bit & b_bit) | (carry_q & (a_bit ^ b_bit));
        carry_d = carry_q;
        if (clr)     carry_d = 1'b0;
        else if (en) carry_d = cout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_d;
    end

    assign carry = carry_q;

endmodule

// File: rtl/sadd_bitcount.sv
module sadd_bitcount #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == LAST_CNT);

    // R10
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && last) |=> (cnt_q == '0));

endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
    import sadd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      start,
    input  logic      last,
    output sadd_ctl_t ctl,
    output logic      busy,
    output logic      done
);

    typedef struct packed {
        sadd_state_e state;
        logic        done;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ctl      = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (load) begin
                    ctl.shift_a = 1'b1;
                    ctl.shift_b = 1'b1;
                    ctl.sel_a   = 1'b1;
                    ctl.sel_b   = 1'b1;
                end else if (start) begin
                    ctl.clr_carry = 1'b1;
                    ctl.clr_cnt   = 1'b1;
                    r_d.state     = ST_RUN;
                end
            end
            ST_RUN: begin
                ctl.shift_a = 1'b1;
                ctl.shift_b = 1'b1;
                if (last) begin
                    r_d.state = ST_DONE;
                    r_d.done  = 1'b1;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, done: 1'b0};
        else        r_q <= r_d;
    end

    assign busy = (r_q.state == ST_RUN);
    assign done = r_q.done;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R4
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4
    last_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last) |=> done);

endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import sadd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             start,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out,
    output logic             busy,
    output logic             done,
    output logic             carry_out
);

    sadd_ctl_t        ctl;
    logic             last;
    logic             sum_bit;
    logic             step;
    logic [WIDTH-1:0] a_q, b_q;

    assign step = ctl.shift_a & ~ctl.sel_a;

    sadd_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .start (start),
        .last  (last),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    sadd_bitcount #(.WIDTH(WIDTH)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.clr_cnt),
        .inc   (step),
        .last  (last)
    );

    sadd_bitcell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (step),
        .clr     (ctl.clr_carry),
        .a_bit   (a_q[0]),
        .b_bit   (b_q[0]),
        .sum_bit (sum_bit),
        .carry   (carry_out)
    );

    sadd_shreg #(.WIDTH(WIDTH)) u_rega (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl.shift_a),
        .sel    (ctl.sel_a),
        .par_in (a_in),
        .ser_in (sum_bit),
        .q      (a_q)
    );

    sadd_shreg #(.WIDTH(WIDTH)) u_regb (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl.shift_b),
        .sel    (ctl.sel_b),
        .par_in (b_in),
        .ser_in (b_q[0]),
        .q      (b_q)
    );

    assign a_out = a_q;
    assign b_out = b_q;

    // R9
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (carry_out == 1'b0));

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy && !done) |=> !busy);

endmodule

// File: tb/sim_serial_adder.sv
module sim_serial_adder;

    localparam int W = 8;
    localparam time PERIOD = 10;
    localparam int NV = 8;

    // {a, b, sum, carry}
    localparam logic [3*W:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'h00, 1'b0},
        {8'hFF, 8'h01, 8'h00, 1'b1},
        {8'h55, 8'hAA, 8'hFF, 1'b0},
        {8'hFF, 8'hFF, 8'hFE, 1'b1},
        {8'h80, 8'h80, 8'h00, 1'b1},
        {8'h0F, 8'h01, 8'h10, 1'b0},
        {8'h3C, 8'hC3, 8'hFF, 1'b0},
        {8'h7F, 8'h01, 8'h80, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         busy, done, carry_out;

    int tests = 0;
    int fails = 0;

    always #(PERIOD/2) clk = ~clk;

    serial_adder #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .start(start),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
        .busy(busy), .done(done), .carry_out(carry_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        load = 1'b1; a_in = a; b_in = b;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Starts an addition; optionally disturbs it mid-run (R8).
    task automatic do_add(input bit disturb, output int nbusy);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nbusy = 0;
        while (!done && nbusy < 40) begin
            if (busy) nbusy++;
            if (disturb && nbusy == 3) begin
                load = 1'b1; start = 1'b1; a_in = 8'hA5; b_in = 8'h5A;
            end else begin
                load = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        load = 1'b0; start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int nb;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(a_out == 0 && b_out == 0 && !busy && !done && !carry_out,
              "R1 reset", {a_out, b_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !carry_out, "R1 after reset", {busy, done, carry_out}, 0);

        // Table walk: R2, R4, R5, R6, R7, R10
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] va, vb, vs;
            logic         vc;
            {va, vb, vs, vc} = VEC[i];
            do_load(va, vb);
            check(a_out == va && b_out == vb, "R2 load", {a_out, b_out}, {va, vb});
            do_add(1'b0, nb);
            check(nb == W, "R4 busy length", nb, W);
            check(done && !busy, "R10 done without busy", {done, busy}, 2'b10);
            check(a_out == vs, "R5 sum", a_out, vs);
            check(b_out == vb, "R6 B kept", b_out, vb);
            check(carry_out == vc, "R7 carry", carry_out, vc);
            @(negedge clk);
            check(!done, "R10 single pulse", done, 0);
        end

        // R3: load and start in the same idle cycle
        @(negedge clk);
        load = 1'b1; start = 1'b1; a_in = 8'h12; b_in = 8'h34;
        @(negedge clk);
        load = 1'b0; start = 1'b0;
        check(!busy && a_out == 8'h12 && b_out == 8'h34, "R3 load wins",
              {busy, a_out, b_out}, {1'b0, 8'h12, 8'h34});
        @(negedge clk);
        check(!busy && !done, "R3 no addition", {busy, done}, 0);

        // R8: load/start during busy are ignored
        do_add(1'b1, nb);
        check(nb == W, "R8 busy length", nb, W);
        check(a_out == 8'h46 && b_out == 8'h34 && !carry_out, "R8 result",
              {a_out, b_out}, {8'h46, 8'h34});
        @(negedge clk);
        check(!busy && !done, "R8 no restart", {busy, done}, 0);

        // R9: carry from previous run must not leak
        do_load(8'hFF, 8'h01);
        do_add(1'b0, nb);
        check(carry_out == 1'b1 && a_out == 8'h00, "R9 setup", {carry_out, a_out}, 9'h100);
        do_load(8'h00, 8'h00);
        do_add(1'b0, nb);
        check(a_out == 8'h00 && !carry_out, "R9 carry cleared", {carry_out, a_out}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule